// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This block sits between a 32-bit processor datapath and a byte-addressed data memory that is one word wide. For stores it works out, in the same cycle as the request, which byte lanes of the memory word to write and where to place the register data in those lanes. For loads it records the access size, signedness and byte offset at the request edge. In the following cycle it selects the addressed lanes from the memory read word and widens them to a full word, with sign or zero extension.

Lanes follow big-endian order, so the lowest byte address in a word holds its most significant byte. Byte accesses may use any offset. Halfword accesses must be 2-byte aligned and word accesses 4-byte aligned. A request that breaks its alignment rule raises a flag, writes nothing, and produces no load data. Only the low bits of the address that select a lane are used. The rest of the address goes to the memory directly and does not pass through this block.

Top module: `be_lane_unit`

## Requirements
- R1: `op_i` uses these codes: 0 none, 1 load word, 2 load signed halfword, 3 load unsigned halfword, 4 load signed byte, 5 load unsigned byte, 6 store word, 7 store halfword, 8 store byte. Codes 9 to 15 behave exactly like code 0.
- R2: Byte offset k (the value of `addr_i[1:0]`) selects data bits [31-8k : 24-8k]. Enable bit `mem_be_o[i]` covers data bits [8i+7 : 8i], so offset k maps to enable bit 3-k.
- R3: A store word at offset 0 sets `mem_be_o` to 4'b1111 and drives `st_data_i` unchanged on `mem_wdata_o`.
- R4: A store halfword copies `st_data_i[15:0]` into both halves of `mem_wdata_o`. It sets `mem_be_o` to 4'b1100 at offset 0 and to 4'b0011 at offset 2.
- R5: A store byte copies `st_data_i[7:0]` into all four lanes and sets exactly one enable bit, bit 3-k for offset k.
- R6: `misalign_o` is 1 in the request cycle for word accesses with `addr_i[1:0]` not equal to 0 and for halfword accesses with `addr_i[0]` equal to 1. Byte accesses never raise it. When it is 1, `mem_be_o` is 0.
- R7: Loads and code 0 drive `mem_be_o` to 0. Code 0 leaves `misalign_o` at 0.
- R8: Load data appears on `ld_data_o` in the cycle after the request. It is taken from `mem_rdata_i` as presented in that later cycle.
- R9: A load word returns `mem_rdata_i` unchanged.
- R10: Halfword loads return the addressed 16 bits, sign-extended for code 2 and zero-extended for code 3.
- R11: Byte loads return the addressed 8 bits, sign-extended for code 4 and zero-extended for code 5.
- R12: When the previous cycle's request was not an aligned load (a store, code 0, an unknown code or a misaligned load), `ld_data_o` is 0.
- R13: While reset is applied, and in the cycles right after it, `ld_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Access operation code |
| addr_i | input | 32 | Byte address of the access |
| st_data_i | input | 32 | Register data for stores |
| mem_rdata_i | input | 32 | Memory read word, one cycle after a load request |
| mem_wdata_o | output | 32 | Lane-placed store data |
| mem_be_o | output | 4 | Per-byte write enables |
| ld_data_o | output | 32 | Extended load result |
| misalign_o | output | 1 | Misaligned access flag |

## Verification
The bench visits every byte offset for byte loads and stores. A design with the lanes mapped little-endian would pick the wrong byte and enable the wrong lane. Halfword loads use data with the top bit both set and clear, so mixing up sign and zero extension shows up. Misaligned halfword and word requests are followed by a check for a zero load result: a design that still enabled lanes would corrupt memory, and one that still captured the load would return stale data. An unknown operation code is included, and the next load result after a store is checked to be zero.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0,
    OP_LW  = 4'd1,
    OP_LH  = 4'd2,
    OP_LHU = 4'd3,
    OP_LB  = 4'd4,
    OP_LBU = 4'd5,
    OP_SW  = 4'd6,
    OP_SH  = 4'd7,
    OP_SB  = 4'd8
  } lsu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } lsu_size_e;

  function automatic logic op_is_load(logic [3:0] op);
    return (op == OP_LW) || (op == OP_LH) || (op == OP_LHU) ||
           (op == OP_LB) || (op == OP_LBU);
  endfunction

  function automatic logic op_is_store(logic [3:0] op);
    return (op == OP_SW) || (op == OP_SH) || (op == OP_SB);
  endfunction

  function automatic logic op_is_signed(logic [3:0] op);
    return (op == OP_LH) || (op == OP_LB);
  endfunction

  function automatic lsu_size_e op_size(logic [3:0] op);
    lsu_size_e sz;
    case (op)
      OP_LW, OP_SW:          sz = SZ_WORD;
      OP_LH, OP_LHU, OP_SH:  sz = SZ_HALF;
      default:               sz = SZ_BYTE;
    endcase
    return sz;
  endfunction

endpackage

// File: rtl/lsu_rst_sync.sv
module lsu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lsu_access_chk.sv
module lsu_access_chk
  import lsu_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [3:0]       op,
  input  logic [OFF_W-1:0] off,
  output lsu_size_e        size,
  output logic             misal,
  output logic             ld_ok,
  output logic             st_ok
);
  logic known;
  logic bad_align;

  always_comb begin
    size  = op_size(op);
    known = op_is_load(op) || op_is_store(op);
    case (size)
      SZ_WORD: bad_align = (off != '0);
      SZ_HALF: bad_align = off[0];
      default: bad_align = 1'b0;
    endcase
    misal = known && bad_align;
    ld_ok = op_is_load(op)  && !bad_align;
    st_ok = op_is_store(op) && !bad_align;
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              st_ok,
  input  lsu_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] sd,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wd
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE_OFF = OFF_W'(LANES - 1 - l);
    logic hit;
    always_comb begin
      case (size)
        SZ_WORD: hit = 1'b1;
        SZ_HALF: hit = (off[OFF_W-1:1] == LANE_OFF[OFF_W-1:1]);
        default: hit = (off == LANE_OFF);
      endcase
    end
    assign be[l] = st_ok && hit;
  end

  always_comb begin
    case (size)
      SZ_WORD: wd = sd;
      SZ_HALF: wd = {(LANES/2){sd[15:0]}};
      default: wd = {LANES{sd[7:0]}};
    endcase
  end
endmodule

// File: rtl/lsu_load_lanes.sv
module lsu_load_lanes
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ok,
  input  lsu_size_e         size,
  input  logic              sgn,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result
);
  logic             vld_q, vld_d;
  lsu_size_e        sz_q, sz_d;
  logic             sgn_q, sgn_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             cap_en;

  always_comb begin
    cap_en = ld_ok;
    vld_d  = ld_ok;
    sz_d   = cap_en ? size : sz_q;
    sgn_d  = cap_en ? sgn  : sgn_q;
    off_d  = cap_en ? off  : off_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sz_q  <= SZ_BYTE;
      sgn_q <= 1'b0;
      off_q <= '0;
    end else begin
      vld_q <= vld_d;
      sz_q  <= sz_d;
      sgn_q <= sgn_d;
      off_q <= off_d;
    end
  end

  logic [7:0]  byte_v;
  logic [15:0] half_v;
  logic [OFF_W-1:0] half_off;

  always_comb begin
    half_off = {off_q[OFF_W-1:1], 1'b0};
    byte_v   = rdata[8*(LANES-1-int'(off_q)) +: 8];
    half_v   = rdata[8*(LANES-2-int'(half_off)) +: 16];
    if (!vld_q) begin
      result = '0;
    end else begin
      case (sz_q)
        SZ_WORD: result = rdata;
        SZ_HALF: result = {{(DATA_W-16){sgn_q & half_v[15]}}, half_v};
        default: result = {{(DATA_W-8){sgn_q & byte_v[7]}}, byte_v};
      endcase
    end
  end
endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int SYNC_STAGES = 2,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              misalign_o
);
  logic             rst_n_int;
  logic [OFF_W-1:0] off;
  lsu_size_e        size;
  logic             ld_ok, st_ok;
  logic             unused_addr_hi;

  assign off            = addr_i[OFF_W-1:0];
  assign unused_addr_hi = ^addr_i[ADDR_W-1:OFF_W];

  lsu_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  lsu_access_chk #(.OFF_W(OFF_W)) i_chk (
    .op(op_i), .off(off), .size(size), .misal(misalign_o),
    .ld_ok(ld_ok), .st_ok(st_ok)
  );

  lsu_store_lanes #(.DATA_W(DATA_W)) i_store (
    .st_ok(st_ok), .size(size), .off(off), .sd(st_data_i),
    .be(mem_be_o), .wd(mem_wdata_o)
  );

  // R6: a misaligned request must not enable any lane
  p_mis_no_be_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    misalign_o |-> (mem_be_o == '0));
  // R5: byte stores enable exactly one lane
  p_sb_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op_i == OP_SB) |-> ($countones(mem_be_o) == 1));
  // R7: loads never write
  p_load_no_be_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    op_is_load(op_i) |-> (mem_be_o == '0));
  // R3: aligned word store enables every lane
  p_sw_full_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((op_i == OP_SW) && !misalign_o) |-> (&mem_be_o));

  lsu_load_lanes #(.DATA_W(DATA_W)) i_load (
    .clk(clk), .rst_n(rst_n_int), .ld_ok(ld_ok), .size(size),
    .sgn(op_is_signed(op_i)), .off(off), .rdata(mem_rdata_i),
    .result(ld_data_o)
  );

  // R9: aligned word load returns the next cycle's read word
  p_lw_pass_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((op_i == OP_LW) && !misalign_o) |=> (ld_data_o == mem_rdata_i));
  // R11: unsigned byte load clears the upper bits
  p_lbu_zx_r11: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op_i == OP_LBU) |=> (ld_data_o[DATA_W-1:8] == '0));
  // R12: no request means no load data next cycle
  p_nop_zero_r12: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op_i == OP_NOP) |=> (ld_data_o == '0));
endmodule

// File: tb/test_be_lane_unit.sv
module test_be_lane_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op_i;
  logic [31:0] addr_i, st_data_i, mem_rdata_i;
  logic [31:0] mem_wdata_o, ld_data_o;
  logic [3:0]  mem_be_o;
  logic        misalign_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // previous-request model state
  bit        p_vld;
  int        p_op;
  int        p_off;

  always #5 clk = ~clk;

  be_lane_unit i_be_lane_unit (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .addr_i(addr_i),
    .st_data_i(st_data_i), .mem_rdata_i(mem_rdata_i),
    .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o),
    .ld_data_o(ld_data_o), .misalign_o(misalign_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit m_mis(int op, int off);
    if (op == 1 || op == 6) return off != 0;
    if (op == 2 || op == 3 || op == 7) return (off % 2) != 0;
    return 0;
  endfunction

  function automatic logic [3:0] m_be(int op, int off);
    if (m_mis(op, off)) return 4'h0;
    if (op == 6) return 4'hf;
    if (op == 7) return (off == 0) ? 4'hc : 4'h3;
    if (op == 8) return 4'(1 << (3 - off));
    return 4'h0;
  endfunction

  function automatic logic [31:0] m_ld(logic [31:0] rd);
    logic [31:0] h, b;
    if (!p_vld) return 32'h0;
    h = (rd >> (8 * (2 - p_off))) & 32'hffff;
    b = (rd >> (8 * (3 - p_off))) & 32'hff;
    case (p_op)
      1: return rd;
      2: return h[15] ? (h | 32'hffff0000) : h;
      3: return h;
      4: return b[7] ? (b | 32'hffffff00) : b;
      5: return b;
      default: return 32'h0;
    endcase
  endfunction

  task automatic step(input string req, input int op, input logic [31:0] a,
                      input logic [31:0] sd, input logic [31:0] rd);
    int off;
    @(negedge clk);
    op_i = 4'(op); addr_i = a; st_data_i = sd; mem_rdata_i = rd;
    off = int'(a[1:0]);
    #2;
    chk({req, " misalign"}, {31'b0, misalign_o}, {31'b0, m_mis(op, off)});
    chk({req, " enables"}, {28'b0, mem_be_o}, {28'b0, m_be(op, off)});
    if (m_be(op, off) != 0) begin
      if (op == 6) chk({req, " wdata"}, mem_wdata_o, sd);
      if (op == 7) chk({req, " wdata"}, mem_wdata_o, {2{sd[15:0]}});
      if (op == 8) chk({req, " wdata"}, mem_wdata_o, {4{sd[7:0]}});
    end
    chk({req, " R8 load result"}, ld_data_o, m_ld(rd));
    p_vld = (op >= 1 && op <= 5) && !m_mis(op, off);
    p_op  = op;
    p_off = off;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_i = 4'd1; addr_i = 0; st_data_i = 0; mem_rdata_i = 32'hffffffff;
    p_vld = 0; p_op = 0; p_off = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R13 reset load result", ld_data_o, 32'h0);
    @(negedge clk); rst_n = 1'b1; op_i = 4'd0;
    step("R13 after reset", 0, 32'h0, 32'h0, 32'hdeadbeef);
    step("R13 after reset", 0, 32'h0, 32'h0, 32'hdeadbeef);
    step("R13 after reset", 0, 32'h0, 32'h0, 32'hdeadbeef);
    // R3 store word, R9 load word
    step("R3 sw", 6, 32'h100, 32'h12345678, 32'h0);
    step("R9 lw", 1, 32'h104, 32'h0, 32'h0);
    step("R9 lw data", 0, 32'h0, 32'h0, 32'hcafef00d);
    // R4 halfword stores both offsets
    step("R4 sh off0", 7, 32'h200, 32'haaaa1234, 32'h0);
    step("R4 sh off2", 7, 32'h202, 32'h5555abcd, 32'h0);
    // R5 R2 byte stores at every offset
    for (int k = 0; k < 4; k++)
      step("R5 R2 sb", 8, 32'h300 + 32'(k), 32'hffffff00 | 32'(k + 8'h90), 32'h0);
    // R11 R2 byte loads signed and unsigned at every offset
    for (int k = 0; k < 4; k++) begin
      step("R11 R2 lb", 4, 32'h400 + 32'(k), 32'h0, 32'h0);
      step("R11 R2 lbu", 5, 32'h400 + 32'(k), 32'h0, 32'h80f17f01);
      step("R11 lbu data", 0, 32'h0, 32'h0, 32'h80f17f01);
    end
    // R10 halfword loads
    step("R10 lh off0", 2, 32'h500, 32'h0, 32'h0);
    step("R10 lhu off2", 3, 32'h502, 32'h0, 32'h8123f00f);
    step("R10 lh off2", 2, 32'h502, 32'h0, 32'h7fff9abc);
    step("R10 lhu off0", 3, 32'h500, 32'h0, 32'h8123f00f);
    step("R10 lhu data", 0, 32'h0, 32'h0, 32'hfedc0000);
    // R6 misaligned accesses, then R12 zero result
    step("R6 lw off3", 1, 32'h603, 32'h0, 32'h0);
    step("R6 R12 sw off2", 6, 32'h602, 32'h11111111, 32'h55555555);
    step("R6 sh off1", 7, 32'h601, 32'h22222222, 32'h55555555);
    step("R6 lhu off3", 3, 32'h603, 32'h0, 32'h55555555);
    step("R12 after misaligned load", 0, 32'h0, 32'h0, 32'h55555555);
    // R1 unknown code acts as none; R7 none drives nothing
    step("R1 lw before unknown", 1, 32'h700, 32'h0, 32'h0);
    step("R1 unknown code", 12, 32'h701, 32'h33333333, 32'h01020304);
    step("R1 R12 after unknown", 0, 32'h0, 32'h0, 32'h01020304);
    step("R7 lb no enables", 4, 32'h701, 32'h0, 32'h0);
    step("R12 store after load", 8, 32'h702, 32'h44, 32'h80808080);
    step("R12 after store", 0, 32'h0, 32'h0, 32'h80808080);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule